// File: doc/BRIEF.md
# Rotating Ring Bus Arbiter Node

This block is the arbitration logic of one node on a shared bus. The nodes are chained into a closed ring by their grant signals: each node takes a grant input from its upstream neighbour and drives a grant output to its downstream neighbour, and the last node's output feeds the first node's input. All nodes drive a common, wired-OR request line. The arbitration role is not fixed at one place. The node that wins the bus also becomes the arbiter, so the role moves around the ring with ownership. This gives round-robin service, and no single node has to stay alive for arbitration to continue.

The arbiter issues a grant only after its own tenure on the bus has ended and it sees the shared request line active. The grant travels downstream. A node that is not asking for the bus passes it on within the same cycle. The first node that is asking absorbs it and becomes both owner and arbiter at the next clock edge. The arbiter that issued the grant gives up its role at that same edge, unless the grant comes back around the ring to itself. A lock input freezes arbitration while nodes join or leave the ring. Under lock, no grant is issued or passed on, an arriving grant is ignored, and the grant is evaluated again once the lock drops. A strap input chooses the node that holds the arbiter role after reset.

Top module: `ring_arb_node`

## Requirements
- R1: While reset is held, and after it is released with all other inputs low, `owns_bus` is 0, `grant_out` is 0, and `has_arb` equals the `boot_arb` strap.
- R2: `req_out` is 1 exactly when `want` is 1 and the node does not own the bus. It is 0 whenever `owns_bus` is 1.
- R3: A node that does not hold the arbiter role and is not requesting copies `grant_in` to `grant_out` in the same cycle while `lock` is 0.
- R4: A requesting node never passes a grant on unless it is itself the issuing arbiter. If `grant_in` is 1 while it is requesting and `lock` is 0, `owns_bus` and `has_arb` are both 1 after the next rising edge.
- R5: The arbiter drives `grant_out` to 1 exactly when it holds the role, does not own the bus, `req_line` is 1 and `lock` is 0.
- R6: An arbiter that issues a grant has `has_arb` 0 after the next edge, unless in that same cycle it takes the grant back on `grant_in` itself.
- R7: An owner that sees `done` at a rising edge has `owns_bus` 0 after that edge and keeps the arbiter role.
- R8: While `lock` is 1, `grant_out` is 0, `grant_in` is ignored, `has_arb` does not change, and `owns_bus` cannot become 1.
- R9: Once `lock` returns to 0, a pending grant is evaluated again with no extra delay. An arbiter with `req_line` still active issues its grant in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| boot_arb | input | 1 | Strap: this node holds the arbiter role after reset |
| want | input | 1 | Local master wants the bus |
| done | input | 1 | Local owner releases the bus |
| lock | input | 1 | Arbitration freeze |
| req_line | input | 1 | Sampled state of the shared request line |
| grant_in | input | 1 | Grant from the upstream neighbour |
| req_out | output | 1 | Drive onto the shared request line |
| grant_out | output | 1 | Grant to the downstream neighbour |
| owns_bus | output | 1 | This node currently owns the bus |
| has_arb | output | 1 | This node currently holds the arbiter role |

## Verification
`req_out` and `grant_out` are combinational. They are due in the same cycle as the input pattern that causes them, so the bench drives every pattern at the falling edge and reads these two outputs one nanosecond later. `owns_bus` and `has_arb` are registered and change at the first rising edge after the stimulus, so they are read one nanosecond after that edge. The bench puts the node into each reachable state: not arbiter, idle arbiter, and owning arbiter. From each state it applies all 32 combinations of `want`, `done`, `lock`, `req_line` and `grant_in`, and checks both the same-cycle outputs and the next-edge state against values it computes from the requirements.

// File: rtl/ring_arb_node.sv
module ring_arb_node (
  input  logic clk,
  input  logic rst_n,
  input  logic boot_arb,
  input  logic want,
  input  logic done,
  input  logic lock,
  input  logic req_line,
  input  logic grant_in,
  output logic req_out,
  output logic grant_out,
  output logic owns_bus,
  output logic has_arb
);
  logic own_q, arb_q;
  logic asking, issue, take, relay;

  assign asking = want & ~own_q;
  assign issue  = arb_q & ~own_q & req_line & ~lock;
  assign take   = grant_in & asking & ~lock;
  assign relay  = ~arb_q & grant_in & ~asking & ~lock;

  assign req_out   = asking;
  assign grant_out = issue | relay;
  assign owns_bus  = own_q;
  assign has_arb   = arb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q <= 1'b0;
      arb_q <= boot_arb;
    end else begin
      own_q <= take | (own_q & ~done);
      arb_q <= take | (arb_q & ~issue);
    end
  end
endmodule

module ring_arb_node_chk (
  input logic clk,
  input logic rst_n,
  input logic done,
  input logic lock,
  input logic req_line,
  input logic grant_in,
  input logic req_out,
  input logic grant_out,
  input logic owns_bus,
  input logic has_arb
);
  assert_no_req_owned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    owns_bus |-> !req_out);
  assert_absorb_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_out && !has_arb) |-> !grant_out);
  assert_take_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_in && req_out && !lock) |=> (owns_bus && has_arb));
  assert_issue_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (has_arb && grant_out) |-> (!owns_bus && req_line && !lock));
  assert_role_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (has_arb && grant_out && !(grant_in && req_out)) |=> !has_arb);
  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (owns_bus && done) |=> (!owns_bus && has_arb));
  assert_owner_arb_R7: assert property (@(posedge clk) disable iff (!rst_n)
    owns_bus |-> has_arb);
  assert_lock_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lock |-> !grant_out);
  assert_lock_role_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(has_arb));
  assert_lock_noown_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> !$rose(owns_bus));
endmodule

bind ring_arb_node ring_arb_node_chk u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .lock(lock), .req_line(req_line),
  .grant_in(grant_in), .req_out(req_out), .grant_out(grant_out),
  .owns_bus(owns_bus), .has_arb(has_arb)
);

// File: tb/sim_ring_arb_node.sv
module sim_ring_arb_node;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic boot_arb = 1'b0;
  logic want = 1'b0, done = 1'b0, lock = 1'b0, req_line = 1'b0, grant_in = 1'b0;
  logic req_out, grant_out, owns_bus, has_arb;
  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  ring_arb_node u0 (
    .clk(clk), .rst_n(rst_n), .boot_arb(boot_arb), .want(want), .done(done),
    .lock(lock), .req_line(req_line), .grant_in(grant_in), .req_out(req_out),
    .grant_out(grant_out), .owns_bus(owns_bus), .has_arb(has_arb)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic zero_inputs();
    want = 0; done = 0; lock = 0; req_line = 0; grant_in = 0;
  endtask

  // state 0: plain node, 1: idle arbiter, 2: owning arbiter
  task automatic enter_state(input int s);
    @(negedge clk);
    zero_inputs();
    boot_arb = (s != 0);
    rst_n = 0;
    #1;
    check("R1", "owns_bus in reset", owns_bus, 1'b0);
    check("R1", "has_arb in reset", has_arb, boot_arb);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1", "owns_bus after reset", owns_bus, 1'b0);
    check("R1", "has_arb after reset", has_arb, boot_arb);
    check("R1", "grant_out after reset", grant_out, 1'b0);
    if (s == 2) begin
      boot_arb = 0;
      want = 1; grant_in = 1;
      @(negedge clk);
      zero_inputs();
      check("R4", "owns_bus after setup take", owns_bus, 1'b1);
      check("R4", "has_arb after setup take", has_arb, 1'b1);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 3; s++) begin
      for (int p = 0; p < 32; p++) begin
        logic o, a, w, d, l, r, g, ask, iss, tk, e_go, e_own, e_arb;
        enter_state(s);
        o = (s == 2);
        a = (s != 0);
        w = p[0]; d = p[1]; l = p[2]; r = p[3]; g = p[4];
        want = w; done = d; lock = l; req_line = r; grant_in = g;
        #1;
        ask  = w & ~o;
        iss  = a & ~o & r & ~l;
        tk   = g & ask & ~l;
        e_go = iss | (~a & g & ~ask & ~l);
        e_own = tk | (o & ~d);
        e_arb = tk | (a & ~iss);
        check("R2", $sformatf("req_out s%0d p%0d", s, p), req_out, ask);
        if (l) check("R8", $sformatf("grant_out locked s%0d p%0d", s, p), grant_out, 1'b0);
        else if (a) check("R5", $sformatf("grant_out arbiter s%0d p%0d", s, p), grant_out, e_go);
        else if (ask) check("R4", $sformatf("grant_out absorbed s%0d p%0d", s, p), grant_out, 1'b0);
        else check("R3", $sformatf("grant_out relay s%0d p%0d", s, p), grant_out, g);
        @(posedge clk);
        #1;
        if (l) begin
          check("R8", $sformatf("owns_bus locked s%0d p%0d", s, p), owns_bus, o & ~d);
          check("R8", $sformatf("has_arb locked s%0d p%0d", s, p), has_arb, a);
        end else if (tk) begin
          check("R4", $sformatf("owns_bus take s%0d p%0d", s, p), owns_bus, 1'b1);
          check("R4", $sformatf("has_arb take s%0d p%0d", s, p), has_arb, 1'b1);
        end else if (o) begin
          check("R7", $sformatf("owns_bus release s%0d p%0d", s, p), owns_bus, e_own);
          check("R7", $sformatf("has_arb kept s%0d p%0d", s, p), has_arb, 1'b1);
        end else begin
          check("R6", $sformatf("owns_bus s%0d p%0d", s, p), owns_bus, e_own);
          check("R6", $sformatf("has_arb s%0d p%0d", s, p), has_arb, e_arb);
        end
      end
    end

    // R9: idle arbiter held under lock, grant appears the cycle lock drops
    enter_state(1);
    req_line = 1; lock = 1;
    #1;
    check("R9", "grant_out while locked", grant_out, 1'b0);
    @(negedge clk);
    check("R9", "has_arb kept under lock", has_arb, 1'b1);
    lock = 0;
    #1;
    check("R9", "grant_out after unlock", grant_out, 1'b1);
    @(posedge clk);
    #1;
    check("R9", "has_arb handed on after unlock", has_arb, 1'b0);

    // R9: plain node with a grant waiting under lock takes it once lock drops
    enter_state(0);
    want = 1; grant_in = 1; lock = 1;
    @(negedge clk);
    check("R9", "owns_bus held off by lock", owns_bus, 1'b0);
    lock = 0;
    @(negedge clk);
    check("R9", "owns_bus after unlock", owns_bus, 1'b1);
    check("R9", "has_arb after unlock", has_arb, 1'b1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule